// File: doc/BRIEF.md
# Byte-Mask Permute Control Generator

This block turns a 128-bit vector of sixteen mask bytes into a 128-bit permute control vector. Each output byte is a lane index for a later byte-permute stage. Only the top bit of each mask byte counts. A running count of the set mask bits across the lanes drives every result.

There are four modes. Two are expansion modes: each set lane gets its rank among the set lanes, and each clear lane gets an out-of-range selector. Two are compression modes: the indices of the set lanes are packed toward one end of the output. One mode of each pair walks the lanes from byte 0 upward. The other walks them from byte 15 downward. A single registered stage sits between the input and the output, with a valid bit carried alongside the data.

The output stage is a two-state machine. ST_EMPTY means no result is presented. ST_FULL means a result is presented. The transitions are:

- FILL: from either state to ST_FULL when a valid input arrives.
- DRAIN: from either state to ST_EMPTY when no valid input arrives.
- CLEAR: reset forces ST_EMPTY.

Top module: `pcv_gen`

## Requirements
- R1: Lane k occupies bits [127-8k:120-8k], so byte 0 is the most significant byte. The only bit that counts in each lane is the most significant bit of its byte, bit [127-8k]. The other seven bits of every byte have no effect on any output.
- R2: In mode 0, a set lane k gets the number of set lanes below k. A clear lane k gets k+16.
- R3: In mode 1, output byte j holds the lane number of the j-th set lane, counting from lane 0. The bytes past the last packed entry are 0x00.
- R4: In mode 2, the walk goes from lane 15 down to lane 0, and step s visits lane 15-s. A set lane gets the number of set lanes above it. A clear lane visited at step s gets s+16.
- R5: In mode 3, for the j-th set lane met in the lane-15-downward walk at step s, output byte 15-j holds s. The bytes below the packed entries are 0x00.
- R6: A mode value from 4 to 31 presents an all-zero output vector and raises out_illegal in the same cycle as out_valid. A legal mode clears out_illegal.
- R7: out_valid in each cycle equals in_valid of the cycle before. The result appears exactly one clock after it is accepted.
- R8: While in_valid is low, out_pcv and out_illegal keep their last values whatever the other inputs do.
- R9: A synchronous active-high reset clears out_valid, out_pcv and out_illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input vector and mode are valid this cycle |
| in_mode | input | 5 | Mode select; 0 to 3 are defined |
| in_mask | input | 128 | Sixteen mask bytes, byte 0 in the top bits |
| out_valid | output | 1 | Registered result is present |
| out_pcv | output | 128 | Permute control vector, byte 0 in the top bits |
| out_illegal | output | 1 | Result came from an undefined mode |

## Verification
Every mask pattern is a possible source of error, so the bench sweeps a dense stride of all 65,536 patterns in each mode. It adds the empty mask, the full mask and every single-lane mask, and fills the seven unused bits of each byte with changing junk.

Several faults show up on these patterns:
- Reading the wrong bit of a byte breaks the junk-bit and top-bit-clear cases.
- Confusing the walk step with the lane number in modes 2 and 3 gives mirrored values for clear lanes and for packed entries.
- A compression unit that leaves stale or duplicated entries fails the zero-fill check on sparse masks.

Undefined modes are driven one by one to catch a decoder that aliases them onto the low two bits. Idle and reset cycles in mid-stream expose a register that loads without a valid input or a latency other than one.

// File: rtl/pcv_pkg.sv
package pcv_pkg;

    // Low two bits of a legal mode field select one of these.
    typedef enum logic [1:0] {
        PM_BE_EXPAND   = 2'd0,
        PM_BE_COMPRESS = 2'd1,
        PM_LE_EXPAND   = 2'd2,
        PM_LE_COMPRESS = 2'd3
    } pcv_mode_e;

    // Output stage occupancy.
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } pcv_state_e;

endpackage

// File: rtl/pcv_prefix.sv
// Two-sided running counts of set lanes: below[i] counts set lanes
// with a smaller number, above[i] counts those with a larger number.
module pcv_prefix #(
    parameter int LANES = 16,
    parameter int CNT_W = 5
) (
    input  logic [LANES-1:0]            sel,
    output logic [LANES-1:0][CNT_W-1:0] below,
    output logic [LANES-1:0][CNT_W-1:0] above
);

    always_comb begin
        logic [CNT_W-1:0] acc_up;
        logic [CNT_W-1:0] acc_dn;
        acc_up = '0;
        acc_dn = '0;
        for (int i = 0; i < LANES; i++) begin
            below[i] = acc_up;
            acc_up   = acc_up + CNT_W'(sel[i]);
        end
        for (int i = LANES - 1; i >= 0; i--) begin
            above[i] = acc_dn;
            acc_dn   = acc_dn + CNT_W'(sel[i]);
        end
    end

endmodule

// File: rtl/pcv_expand.sv
// Per-lane expansion result: rank for a set lane, offset selector otherwise.
module pcv_expand #(
    parameter int LANES  = 16,
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 5
) (
    input  logic [LANES-1:0]             sel,
    input  logic [LANES-1:0][CNT_W-1:0]  below,
    input  logic [LANES-1:0][CNT_W-1:0]  above,
    input  logic                         rev,
    output logic [LANES-1:0][BYTE_W-1:0] lane_byte
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int FWD_OFF = LANES + i;
        localparam int REV_OFF = LANES + (LANES - 1 - i);
        always_comb begin
            if (sel[i])
                lane_byte[i] = rev ? BYTE_W'(above[i]) : BYTE_W'(below[i]);
            else
                lane_byte[i] = rev ? BYTE_W'(REV_OFF) : BYTE_W'(FWD_OFF);
        end
    end

endmodule

// File: rtl/pcv_compress.sv
// Packs indices of set lanes; each output slot ORs the one lane whose
// rank matches it, so unused slots stay zero.
module pcv_compress #(
    parameter int LANES  = 16,
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 5
) (
    input  logic [LANES-1:0]             sel,
    input  logic [LANES-1:0][CNT_W-1:0]  below,
    input  logic [LANES-1:0][CNT_W-1:0]  above,
    input  logic                         rev,
    output logic [LANES-1:0][BYTE_W-1:0] slot_byte
);

    for (genvar k = 0; k < LANES; k++) begin : g_slot
        localparam int DST = LANES - 1 - k;
        logic [BYTE_W-1:0] fwd_val;
        logic [BYTE_W-1:0] rev_val;
        always_comb begin
            fwd_val = '0;
            rev_val = '0;
            for (int i = 0; i < LANES; i++) begin
                if (sel[i] && below[i] == CNT_W'(k))
                    fwd_val = fwd_val | BYTE_W'(i);
                if (sel[i] && above[i] == CNT_W'(DST))
                    rev_val = rev_val | BYTE_W'(LANES - 1 - i);
            end
            slot_byte[k] = rev ? rev_val : fwd_val;
        end
    end

endmodule

// File: rtl/pcv_gen.sv
module pcv_gen #(
    parameter int LANES  = 16,
    parameter int BYTE_W = 8,
    parameter int MODE_W = 5
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [MODE_W-1:0]         in_mode,
    input  logic [LANES*BYTE_W-1:0]   in_mask,
    output logic                      out_valid,
    output logic [LANES*BYTE_W-1:0]   out_pcv,
    output logic                      out_illegal
);
    import pcv_pkg::*;

    localparam int IDX_W = $clog2(LANES);
    localparam int CNT_W = IDX_W + 1;
    localparam int VEC_W = LANES * BYTE_W;

    logic [LANES-1:0]             sel;
    logic [LANES-1:0][CNT_W-1:0]  below;
    logic [LANES-1:0][CNT_W-1:0]  above;
    logic [LANES-1:0][BYTE_W-1:0] exp_b;
    logic [LANES-1:0][BYTE_W-1:0] cmp_b;
    logic [VEC_W-1:0]             nxt_pcv;
    logic                         legal;
    logic                         rev;
    pcv_mode_e                    mode;
    pcv_state_e                   state_q, state_d;
    logic [VEC_W-1:0]             pcv_q;
    logic                         ill_q;

    // Lane k lives in the k-th byte from the top; its flag is that byte's MSB.
    for (genvar k = 0; k < LANES; k++) begin : g_sel
        assign sel[k] = in_mask[(LANES - 1 - k) * BYTE_W + BYTE_W - 1];
    end

    assign legal = (in_mode[MODE_W-1:2] == '0);
    assign mode  = pcv_mode_e'(in_mode[1:0]);
    assign rev   = in_mode[1];

    pcv_prefix #(.LANES(LANES), .CNT_W(CNT_W)) u_prefix (
        .sel   (sel),
        .below (below),
        .above (above)
    );

    pcv_expand #(.LANES(LANES), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_expand (
        .sel       (sel),
        .below     (below),
        .above     (above),
        .rev       (rev),
        .lane_byte (exp_b)
    );

    pcv_compress #(.LANES(LANES), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_compress (
        .sel       (sel),
        .below     (below),
        .above     (above),
        .rev       (rev),
        .slot_byte (cmp_b)
    );

    // Result selection by mode, repacked with byte 0 at the top.
    always_comb begin
        nxt_pcv = '0;
        if (legal) begin
            for (int k = 0; k < LANES; k++) begin
                unique case (mode)
                    PM_BE_EXPAND, PM_LE_EXPAND:
                        nxt_pcv[(LANES - 1 - k) * BYTE_W +: BYTE_W] = exp_b[k];
                    PM_BE_COMPRESS, PM_LE_COMPRESS:
                        nxt_pcv[(LANES - 1 - k) * BYTE_W +: BYTE_W] = cmp_b[k];
                endcase
            end
        end
    end

    // Next-state logic: FILL / DRAIN.
    always_comb begin
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
        endcase
    end

    // State register, with CLEAR on reset.
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_EMPTY;
        else
            state_q <= state_d;
    end

    // Output data register: loads only on FILL.
    always_ff @(posedge clk) begin
        if (rst) begin
            pcv_q <= '0;
            ill_q <= 1'b0;
        end else if (in_valid) begin
            pcv_q <= nxt_pcv;
            ill_q <= ~legal;
        end
    end

    assign out_valid   = (state_q == ST_FULL);
    assign out_pcv     = pcv_q;
    assign out_illegal = ill_q;

endmodule

// File: rtl/pcv_gen_chk.sv
module pcv_gen_chk #(
    parameter int LANES  = 16,
    parameter int BYTE_W = 8,
    parameter int MODE_W = 5
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic [MODE_W-1:0]       in_mode,
    input logic [LANES*BYTE_W-1:0] in_mask,
    input logic                    out_valid,
    input logic [LANES*BYTE_W-1:0] out_pcv,
    input logic                    out_illegal
);
    localparam int VEC_W = LANES * BYTE_W;

    logic no_flags;
    always_comb begin
        no_flags = 1'b1;
        for (int k = 0; k < LANES; k++)
            if (in_mask[k * BYTE_W + BYTE_W - 1]) no_flags = 1'b0;
    end

    assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_pcv) && $stable(out_illegal)));

    assert_zero_out_R6: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (out_pcv == '0));

    assert_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode[MODE_W-1:2] != '0) |=> (out_illegal && out_valid));

    assert_legal_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode[MODE_W-1:2] == '0) |=> !out_illegal);

    assert_head_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == MODE_W'(0)) |=>
        (out_pcv[VEC_W-1 -: BYTE_W] ==
         ($past(in_mask[VEC_W-1]) ? BYTE_W'(0) : BYTE_W'(LANES))));

    assert_tail_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == MODE_W'(2)) |=>
        (out_pcv[BYTE_W-1:0] ==
         ($past(in_mask[BYTE_W-1]) ? BYTE_W'(0) : BYTE_W'(LANES))));

    assert_empty_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && no_flags && (in_mode == MODE_W'(1) || in_mode == MODE_W'(3)))
        |=> (out_pcv == '0));

    assert_reset_R9: assert property (@(posedge clk)
        rst |=> (!out_valid && out_pcv == '0 && !out_illegal));

endmodule

bind pcv_gen pcv_gen_chk #(.LANES(LANES), .BYTE_W(BYTE_W), .MODE_W(MODE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_mode     (in_mode),
    .in_mask     (in_mask),
    .out_valid   (out_valid),
    .out_pcv     (out_pcv),
    .out_illegal (out_illegal)
);

// File: tb/tb_pcv_gen.sv
`timescale 1ns/1ps
module tb_pcv_gen;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [4:0]   in_mode = '0;
    logic [127:0] in_mask = '0;
    logic         out_valid;
    logic [127:0] out_pcv;
    logic         out_illegal;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    pcv_gen dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .in_mask(in_mask), .out_valid(out_valid), .out_pcv(out_pcv),
        .out_illegal(out_illegal)
    );

    // Walk-based reference built straight from the mode descriptions.
    function automatic logic [127:0] model(input logic [127:0] m, input logic [4:0] md);
        logic [7:0]   ob [16];
        logic [127:0] r;
        int j;
        for (int k = 0; k < 16; k++) ob[k] = 8'h00;
        j = 0;
        case (md)
            5'd0: for (int i = 0; i < 16; i++)
                      if (m[(15 - i) * 8 + 7]) begin ob[i] = 8'(j); j++; end
                      else ob[i] = 8'(i + 16);
            5'd1: for (int i = 0; i < 16; i++)
                      if (m[(15 - i) * 8 + 7]) begin ob[j] = 8'(i); j++; end
            5'd2: for (int i = 0; i < 16; i++)
                      if (m[i * 8 + 7]) begin ob[15 - i] = 8'(j); j++; end
                      else ob[15 - i] = 8'(i + 16);
            5'd3: for (int i = 0; i < 16; i++)
                      if (m[i * 8 + 7]) begin ob[15 - j] = 8'(i); j++; end
            default: ;
        endcase
        for (int k = 0; k < 16; k++) r[(15 - k) * 8 +: 8] = ob[k];
        return r;
    endfunction

    // 16 lane flags plus changing junk in the low seven bits of each byte (R1).
    function automatic logic [127:0] build(input logic [15:0] f, input int seed);
        logic [127:0] r;
        for (int k = 0; k < 16; k++)
            r[(15 - k) * 8 +: 8] = {f[k], 7'((seed * 37 + k * 11 + 5) & 7'h7f)};
        return r;
    endfunction

    function automatic string tag_of(input logic [4:0] md);
        case (md)
            5'd0: return "R2";
            5'd1: return "R3";
            5'd2: return "R4";
            5'd3: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic send(input logic [127:0] m, input logic [4:0] md, input string tag);
        logic [127:0] exp_v;
        @(negedge clk);
        in_valid = 1'b1;
        in_mode  = md;
        in_mask  = m;
        exp_v    = model(m, md);
        @(posedge clk);
        #1;
        checks++;
        if (out_valid !== 1'b1 || out_pcv !== exp_v || out_illegal !== (md > 5'd3)) begin
            fails++;
            $display("FAIL %s mode=%0d mask=%h: actual v=%b ill=%b pcv=%h expected v=1 ill=%b pcv=%h",
                     tag, md, m, out_valid, out_illegal, out_pcv, (md > 5'd3), exp_v);
        end
    endtask

    // Idle cycle with scrambled inputs: data must hold, valid must drop (R7, R8).
    task automatic idle_check();
        logic [127:0] prev_p;
        logic         prev_i;
        prev_p = out_pcv;
        prev_i = out_illegal;
        @(negedge clk);
        in_valid = 1'b0;
        in_mode  = ~in_mode;
        in_mask  = ~in_mask;
        @(posedge clk);
        #1;
        checks++;
        if (out_valid !== 1'b0 || out_pcv !== prev_p || out_illegal !== prev_i) begin
            fails++;
            $display("FAIL R7/R8 idle: actual v=%b ill=%b pcv=%h expected v=0 ill=%b pcv=%h",
                     out_valid, out_illegal, out_pcv, prev_i, prev_p);
        end
    endtask

    task automatic reset_check(input string tag);
        checks++;
        if (out_valid !== 1'b0 || out_pcv !== '0 || out_illegal !== 1'b0) begin
            fails++;
            $display("FAIL %s reset: actual v=%b ill=%b pcv=%h expected v=0 ill=0 pcv=0",
                     tag, out_valid, out_illegal, out_pcv);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog: actual run still busy, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        reset_check("R9");
        @(negedge clk);
        rst = 1'b0;

        // R1: flag bit clear, all other bits set -> every lane clear.
        send({16{8'h7f}}, 5'd0, "R1");
        send({16{8'h80}}, 5'd1, "R1");
        // Corner masks in every mode.
        for (int md = 0; md < 4; md++) begin
            send(build(16'h0000, md), 5'(md), tag_of(5'(md)));
            send(build(16'hffff, md), 5'(md), tag_of(5'(md)));
            for (int b = 0; b < 16; b++)
                send(build(16'(1 << b), b + md), 5'(md), tag_of(5'(md)));
        end
        idle_check();
        // Dense sweep of mask patterns per mode, back to back.
        for (int md = 0; md < 4; md++)
            for (int f = md; f < 65536; f += 5)
                send(build(16'(f), f), 5'(md), tag_of(5'(md)));
        idle_check();
        // R6: every undefined mode, each followed by a legal one.
        for (int md = 4; md < 32; md++) begin
            send(build(16'(md * 2749), md), 5'(md), "R6");
            send(build(16'(md * 977), md), 5'(md & 3), tag_of(5'(md & 3)));
        end
        send(build(16'h5a5a, 3), 5'd17, "R6");
        idle_check();
        idle_check();
        // R9: reset while a valid input is offered.
        send(build(16'h1234, 9), 5'd1, "R3");
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;
        @(posedge clk);
        #1;
        reset_check("R9");
        @(negedge clk);
        rst = 1'b0;
        send(build(16'h8001, 4), 5'd3, "R5");
        idle_check();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule